// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block collects seven interrupt request lines for a small microcontroller core and decides which of them, if any, is forwarded to the CPU. The sources, in polling order, are: external 0 (index 0), timer 0 (1), external 1 (2), timer 1 (3), closed-caption data (4), second serial port (5) and bus-busy (6). Software reaches two byte-wide configuration registers through a simple write/read port. The mask register holds one enable bit per source and a master enable. The level register holds one high/low priority bit per source.

The CPU sees a level `irq_o`. It answers with a one-cycle acknowledge strobe, which records the winning source index on `irq_vec_o` and marks the granted priority level as in service. A return strobe closes the innermost active handler. The block keeps one in-service flag per level, so a high-priority request can nest inside a low-priority handler. Nothing can nest inside a high-priority handler. Sources selected as edge type keep a pending flag from their rising edge until they are acknowledged. All other sources are sampled live on every cycle.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset both configuration registers read 0, `irq_o` is 0, `irq_vec_o` is 0 and both in-service flags are 0.
- R2: Mask register (select 0) bit i enables source i, for i = 0..6. A source whose bit is 0 never causes `irq_o`.
- R3: Mask register bit 7 is the master enable. While it is 0, `irq_o` stays 0 whatever the per-source bits hold.
- R4: Level register (select 1) bit i = 1 puts source i at high priority and 0 puts it at low priority. Bits 0..6 read back as written, and bit 7 reads 0.
- R5: When an enabled high request and an enabled low request are pending together, the acknowledge grants the high one.
- R6: Among pending requests of one level, the lowest source index is granted.
- R7: An acknowledge while `irq_o` is 1 sets the in-service flag of the granted level and loads the granted index into `irq_vec_o`. At all other times `irq_vec_o` holds its value.
- R8: While only the low flag is set, low requests do not raise `irq_o`, and high requests still do.
- R9: While the high flag is set, `irq_o` is 0.
- R10: A return strobe clears the high flag if it is set. Otherwise it clears the low flag.
- R11: Edge sources (default: indices 0 and 2) latch a rising edge that stays pending after the line falls, until that source is acknowledged. A level source stops requesting as soon as its line drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 7 | Request lines, index = polling order |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 0 selects mask register, 1 selects level register |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data of the selected register |
| cpu_ack_i | input | 1 | CPU acknowledge strobe |
| cpu_reti_i | input | 1 | CPU return-from-handler strobe |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | 3 | Index of the last acknowledged source |
| svc_hi_o | output | 1 | High-level handler in service |
| svc_lo_o | output | 1 | Low-level handler in service |

## Verification
The bench nests a high handler inside a low one. A design that tracked one shared in-service flag would either let a second low request in or block the high one. It then unwinds with two return strobes. Clearing the wrong flag first would leave the low handler marked active or reopen it early. Simultaneous high and low requests, and several same-level requests, expose a reversed polling order or ignored level bits. A one-cycle pulse on an edge source that must still be granted afterwards, followed by a check that the grant clears it, catches a design that samples edge lines live or never drops the pending flag.

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int NSRC = 7,
  parameter logic [NSRC-1:0] EDGE_MASK = 7'b0000101,
  localparam int IW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req_i,
  input  logic            cfg_wr_i,
  input  logic            cfg_sel_i,
  input  logic [7:0]      cfg_wdata_i,
  output logic [7:0]      cfg_rdata_o,
  input  logic            cpu_ack_i,
  input  logic            cpu_reti_i,
  output logic            irq_o,
  output logic [IW-1:0]   irq_vec_o,
  output logic            svc_hi_o,
  output logic            svc_lo_o
);

  logic [NSRC-1:0] en_q, prio_q, req_q, edge_q, pend, act, hi_act, lo_act;
  logic            glb_en;
  logic [IW-1:0]   win_idx;
  logic            win_hi, grant;

  function automatic logic [IW-1:0] first_set(input logic [NSRC-1:0] v);
    first_set = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (v[i]) first_set = IW'(i);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      glb_en <= 1'b0;
      prio_q <= '0;
    end else if (cfg_wr_i) begin
      if (cfg_sel_i) prio_q <= cfg_wdata_i[NSRC-1:0];
      else begin
        en_q   <= cfg_wdata_i[NSRC-1:0];
        glb_en <= cfg_wdata_i[7];
      end
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_sel_i) cfg_rdata_o[NSRC-1:0] = prio_q;
    else begin
      cfg_rdata_o[NSRC-1:0] = en_q;
      cfg_rdata_o[7]        = glb_en;
    end
  end

  assign pend   = (EDGE_MASK & edge_q) | (~EDGE_MASK & irq_req_i);
  assign act    = pend & en_q & {NSRC{glb_en}};
  assign hi_act = act & prio_q;
  assign lo_act = act & ~prio_q;
  assign win_hi = |hi_act;
  assign win_idx = win_hi ? first_set(hi_act) : first_set(lo_act);
  assign irq_o  = !svc_hi_o && (win_hi || (!svc_lo_o && |lo_act));
  assign grant  = cpu_ack_i && irq_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      edge_q <= '0;
    end else begin
      req_q <= irq_req_i;
      for (int i = 0; i < NSRC; i++)
        if (irq_req_i[i] && !req_q[i])         edge_q[i] <= 1'b1;
        else if (grant && win_idx == IW'(i))   edge_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_hi_o  <= 1'b0;
      svc_lo_o  <= 1'b0;
      irq_vec_o <= '0;
    end else if (grant) begin
      irq_vec_o <= win_idx;
      if (win_hi) svc_hi_o <= 1'b1;
      else        svc_lo_o <= 1'b1;
    end else if (cpu_reti_i) begin
      if (svc_hi_o) svc_hi_o <= 1'b0;
      else          svc_lo_o <= 1'b0;
    end
  end

endmodule

module irq_nest_ctrl_chk #(parameter int IW = 3) (
  input logic          clk,
  input logic          rst_n,
  input logic          glb,
  input logic          ack,
  input logic          reti,
  input logic          irq,
  input logic [IW-1:0] vec,
  input logic          s_hi,
  input logic          s_lo
);
  assert_hi_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n) s_hi |-> !irq);
  assert_master_off_R3: assert property (@(posedge clk) disable iff (!rst_n) !glb |-> !irq);
  assert_ack_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> (s_hi || s_lo));
  assert_vec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(vec));
  assert_reti_hi_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack && s_hi) |=> (!s_hi && $stable(s_lo)));
  assert_nest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && s_lo) |=> s_hi);
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb(glb_en), .ack(cpu_ack_i), .reti(cpu_reti_i),
  .irq(irq_o), .vec(irq_vec_o), .s_hi(svc_hi_o), .s_lo(svc_lo_o)
);

// File: tb/irq_nest_ctrl_tb.sv
`timescale 1ns/1ps
module irq_nest_ctrl_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [6:0] req = '0;
  logic       wr = 1'b0, sel = 1'b0, ack = 1'b0, reti = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       irq, s_hi, s_lo;
  logic [2:0] vec;
  int n_cmp = 0, n_bad = 0;
  logic [3:0] exp_q[$];
  logic ack_seen = 1'b0;

  always #2 clk = ~clk;

  irq_nest_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req_i(req), .cfg_wr_i(wr), .cfg_sel_i(sel),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .cpu_ack_i(ack), .cpu_reti_i(reti),
    .irq_o(irq), .irq_vec_o(vec), .svc_hi_o(s_hi), .svc_lo_o(s_lo)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) ack_seen <= ack && irq;

  always @(negedge clk) if (ack_seen) begin
    logic [3:0] e;
    if (exp_q.size() == 0) chk("R7 unexpected grant", 8'd1, 8'd0);
    else begin
      e = exp_q.pop_front();
      chk("R7 vector", {5'd0, vec}, {5'd0, e[2:0]});
      chk("R7 level flag", {7'd0, e[3] ? s_hi : s_lo}, 8'd1);
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic smp(); @(negedge clk); endtask

  task automatic wr_reg(logic s, logic [7:0] d);
    sel = s; wdata = d; wr = 1'b1; cyc(); wr = 1'b0;
  endtask

  task automatic grant(logic hi, logic [2:0] idx);
    exp_q.push_back({hi, idx});
    ack = 1'b1; cyc(); ack = 1'b0; smp();
  endtask

  task automatic ret(); reti = 1'b1; cyc(); reti = 1'b0; smp(); endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog", 8'd1, 8'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1; smp();
    sel = 1'b0; #0.1;
    chk("R1 mask", rdata, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 vec", {5'd0, vec}, 8'd0);
    chk("R1 flags", {6'd0, s_hi, s_lo}, 8'd0);
    sel = 1'b1; #0.1;
    chk("R1 level", rdata, 8'h00);

    cyc(); wr_reg(0, 8'h7F); req = 7'b0000010; smp();
    chk("R3 master off", {7'd0, irq}, 8'd0);
    cyc(); wr_reg(0, 8'hFF); smp();
    chk("R2 enabled", {7'd0, irq}, 8'd1);
    chk("R2 readback", rdata, 8'hFF);
    cyc(); wr_reg(1, 8'hFF); smp();
    chk("R4 readback", rdata, 8'h7F);
    cyc(); wr_reg(1, 8'h00); wr_reg(0, 8'h82); req = 7'b0001000; smp();
    chk("R2 masked source", {7'd0, irq}, 8'd0);

    cyc(); wr_reg(0, 8'hFF); req = 7'b1001010; smp();
    grant(1'b0, 3'd1);
    chk("R8 low blocked", {7'd0, irq}, 8'd0);
    cyc(); wr_reg(1, 8'h40); smp();
    chk("R8 high passes", {7'd0, irq}, 8'd1);
    grant(1'b1, 3'd6);
    cyc(); wr_reg(1, 8'h48); smp();
    chk("R9 high in service", {7'd0, irq}, 8'd0);
    ret();
    chk("R10 high cleared first", {6'd0, s_hi, s_lo}, 8'd1);
    ret();
    chk("R10 low cleared", {6'd0, s_hi, s_lo}, 8'd0);

    cyc(); wr_reg(1, 8'h08); smp();
    grant(1'b1, 3'd3);
    chk("R5 high beats low", {5'd0, vec}, 8'd3);
    ret();

    cyc(); req = '0; wr_reg(1, 8'h00); smp();
    chk("R11 idle", {7'd0, irq}, 8'd0);
    cyc(); req = 7'b0000101; cyc(); req = '0; smp();
    chk("R11 edge held", {7'd0, irq}, 8'd1);
    grant(1'b0, 3'd0);
    ret();
    chk("R6 next edge pending", {7'd0, irq}, 8'd1);
    grant(1'b0, 3'd2);
    ret();
    chk("R11 edge cleared by grant", {7'd0, irq}, 8'd0);
    cyc(); req = 7'b0010000; smp();
    chk("R11 level present", {7'd0, irq}, 8'd1);
    cyc(); req = '0; smp();
    chk("R11 level dropped", {7'd0, irq}, 8'd0);

    cyc(); cyc();
    chk("R7 scoreboard empty", 8'(exp_q.size()), 8'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule